// File: doc/BRIEF.md
# SPI Register Access Slave

This block is an SPI slave that lets an external host read and write a 128-entry, byte-wide register space. It sits between the SPI pins and a register file. Each transaction opens with a command byte: an access bit and a 7-bit register address. While the host shifts in its first two bytes, the slave shifts out a 16-bit status word, high byte first. Reads are pipelined, so the host can stream read-address bytes in any order. Each register value comes back two byte slots after its address went in. The host closes a read stream with bytes that name the flush address 3Fh. A write sends one start address, then any number of data bytes, and the slave stores them at consecutive addresses.

The SPI pins are synchronised into the system clock domain, and SPI clock edges are detected there. The control flow is a four-state machine:
- `ST_IDLE` (select high) moves to `ST_CMD` on a select falling edge.
- `ST_CMD` waits for the command byte. It moves to `ST_RD` when the access bit is 1 and to `ST_WR` when it is 0.
- `ST_RD` and `ST_WR` stay put until select rises.
- A rising select returns any state to `ST_IDLE`.

A separate byte-slot tracker moves through `SLOT_STAT_HI`, `SLOT_STAT_LO` and `SLOT_DATA`, and stays in `SLOT_DATA`. It chooses what is loaded into the MISO shifter at each byte boundary.

Top module: `spi_regif`

## Requirements
- R1: SPI mode 0, MSB first. The first byte after select falls is the command. Bit 7 is the access bit (1 = read, 0 = write) and bits 6:0 are the register address.
- R2: MISO carries status bits 15:8 in byte slot 0 and status bits 7:0 in byte slot 1.
- R3: Both status bytes come from the status input sampled when select falls. Later changes of that input within the transaction have no effect on them.
- R4: In a read, the register named by a read byte in slot n is returned on MISO in slot n+2. Read bytes may follow back to back, naming addresses in any order.
- R5: A read byte naming the flush address 3Fh produces no register read strobe, and its slot n+2 carries 00h.
- R6: In a write, the data byte after the command byte is stored at the command address.
- R7: Further write data bytes go to consecutive addresses. The address steps by one per stored byte and wraps from 7Fh to 00h.
- R8: Within a read stream, a byte whose bit 7 is 0 causes neither a read nor a write strobe, and its slot n+2 carries 00h.
- R9: Raising select aborts the transaction. A partly received byte causes no strobe, and the next transaction starts again with the command byte and the status bytes.
- R10: The read and write strobes are each one clock long and are never high together.
- R11: MISO is driven low while select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sel_n | input | 1 | SPI select, active low |
| spi_sck | input | 1 | SPI clock from host |
| spi_sdi | input | 1 | Host-to-slave serial data (MOSI) |
| spi_sdo | output | 1 | Slave-to-host serial data (MISO) |
| stat_word | input | 16 | Status word returned at the start of each transaction |
| reg_addr | output | 7 | Register file address |
| reg_rd_en | output | 1 | Register read strobe, one clock |
| reg_rd_data | input | 8 | Read data, valid the clock after the read strobe |
| reg_wr_en | output | 1 | Register write strobe, one clock |
| reg_wr_data | output | 8 | Register write data |

## Verification
Each synchronised SPI edge reaches the logic three clocks after the pin changes. A read strobe follows one clock after a byte completes. The register data is captured two clocks after that and is shifted into place at the next byte boundary. The MISO bit for a slot is therefore stable well before the host's next rising SPI clock. The bench holds every SPI half-period for eight system clocks and samples MISO just before it raises the SPI clock, as a mode-0 host would. Each expected register value comes from the bench's own image of the register space. Every write is confirmed by reading it back through a later SPI transaction, and strobe counts are compared before and after each scenario.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_RD,
        ST_WR
    } xfer_state_t;

    typedef enum logic [1:0] {
        SLOT_STAT_HI,
        SLOT_STAT_LO,
        SLOT_DATA
    } slot_t;

endpackage

// File: rtl/spi_sync_edge.sv
module spi_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n_raw,
    input  logic sck_raw,
    input  logic sdi_raw,
    output logic sel_s,
    output logic sdi_s,
    output logic sel_fall,
    output logic sck_rise,
    output logic sck_fall
);
    localparam int NSIG = 3;
    // bit 0 select (idles high), bit 1 clock, bit 2 data
    localparam logic [NSIG-1:0] RST_VAL = 3'b001;

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] synced;
    logic            sel_d;
    logic            sck_d;

    assign raw = {sdi_raw, sck_raw, sel_n_raw};

    for (genvar g = 0; g < NSIG; g++) begin : g_sync
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
            else        chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_d <= 1'b1;
            sck_d <= 1'b0;
        end else begin
            sel_d <= synced[0];
            sck_d <= synced[1];
        end
    end

    assign sel_s    = synced[0];
    assign sdi_s    = synced[2];
    assign sel_fall = sel_d & ~synced[0];
    assign sck_rise = ~synced[0] & synced[1] & ~sck_d;
    assign sck_fall = ~synced[0] & ~synced[1] & sck_d;

endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift #(
    parameter int DATA_W = 8,
    localparam int CW = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_s,
    input  logic              sck_rise,
    input  logic              sdi_s,
    output logic [CW-1:0]     bit_cnt,
    output logic              byte_done,
    output logic [DATA_W-1:0] rx_byte
);
    logic [DATA_W-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            byte_done <= 1'b0;
            rx_byte   <= '0;
        end else begin
            byte_done <= 1'b0;
            if (sel_s) begin
                bit_cnt <= '0;
                shreg   <= '0;
            end else if (sck_rise) begin
                shreg <= {shreg[DATA_W-2:0], sdi_s};
                if (bit_cnt == CW'(DATA_W - 1)) begin
                    bit_cnt   <= '0;
                    byte_done <= 1'b1;
                    rx_byte   <= {shreg[DATA_W-2:0], sdi_s};
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
    parameter int DATA_W = 8,
    localparam int CW = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_s,
    input  logic              sel_fall,
    input  logic              sck_fall,
    input  logic [CW-1:0]     bit_cnt,
    input  logic [DATA_W-1:0] first_byte,
    input  logic [DATA_W-1:0] next_byte,
    output logic              sdo
);
    logic [DATA_W-1:0] tx_reg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_reg <= '0;
            sdo    <= 1'b0;
        end else if (sel_s) begin
            tx_reg <= '0;
            sdo    <= 1'b0;
        end else if (sel_fall) begin
            tx_reg <= first_byte;
            sdo    <= first_byte[DATA_W-1];
        end else if (sck_fall) begin
            if (bit_cnt == '0) begin
                tx_reg <= next_byte;
                sdo    <= next_byte[DATA_W-1];
            end else begin
                tx_reg <= {tx_reg[DATA_W-2:0], 1'b0};
                sdo    <= tx_reg[DATA_W-2];
            end
        end
    end

endmodule

// File: rtl/spi_regif.sv
module spi_regif
    import spi_regif_pkg::*;
#(
    parameter int             ADDR_W      = 7,
    parameter int             DATA_W      = 8,
    parameter int             SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] DUMMY_ADDR = 7'h3F
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                spi_sel_n,
    input  logic                spi_sck,
    input  logic                spi_sdi,
    output logic                spi_sdo,
    input  logic [2*DATA_W-1:0] stat_word,
    output logic [ADDR_W-1:0]   reg_addr,
    output logic                reg_rd_en,
    input  logic [DATA_W-1:0]   reg_rd_data,
    output logic                reg_wr_en,
    output logic [DATA_W-1:0]   reg_wr_data
);
    localparam int STAT_W = 2 * DATA_W;
    localparam int CW     = $clog2(DATA_W);

    logic              sel_s, sdi_s, sel_fall, sck_rise, sck_fall;
    logic [CW-1:0]     bit_cnt;
    logic              byte_done;
    logic [DATA_W-1:0] rx_byte;

    xfer_state_t       state, state_nxt;
    slot_t             slot;
    logic [DATA_W-1:0] stat_lo;
    logic [DATA_W-1:0] stage1, stage2;
    logic              cap_pend;
    logic [ADDR_W-1:0] wr_ptr;
    logic [DATA_W-1:0] next_byte;
    logic              cmd_rd;
    logic [ADDR_W-1:0] cmd_addr;

    assign cmd_rd   = rx_byte[DATA_W-1];
    assign cmd_addr = rx_byte[ADDR_W-1:0];

    spi_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_n_raw (spi_sel_n),
        .sck_raw   (spi_sck),
        .sdi_raw   (spi_sdi),
        .sel_s     (sel_s),
        .sdi_s     (sdi_s),
        .sel_fall  (sel_fall),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall)
    );

    spi_rx_shift #(.DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_s     (sel_s),
        .sck_rise  (sck_rise),
        .sdi_s     (sdi_s),
        .bit_cnt   (bit_cnt),
        .byte_done (byte_done),
        .rx_byte   (rx_byte)
    );

    assign next_byte = (slot == SLOT_STAT_LO) ? stat_lo : stage2;

    spi_tx_shift #(.DATA_W(DATA_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_s      (sel_s),
        .sel_fall   (sel_fall),
        .sck_fall   (sck_fall),
        .bit_cnt    (bit_cnt),
        .first_byte (stat_word[STAT_W-1:DATA_W]),
        .next_byte  (next_byte),
        .sdo        (spi_sdo)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (sel_fall) state_nxt = ST_CMD;
            ST_CMD: begin
                if (sel_s)          state_nxt = ST_IDLE;
                else if (byte_done) state_nxt = cmd_rd ? ST_RD : ST_WR;
            end
            ST_RD:   if (sel_s) state_nxt = ST_IDLE;
            ST_WR:   if (sel_s) state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // outputs, slot tracking and read pipeline
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_addr    <= '0;
            reg_rd_en   <= 1'b0;
            reg_wr_en   <= 1'b0;
            reg_wr_data <= '0;
            slot        <= SLOT_STAT_HI;
            stat_lo     <= '0;
            stage1      <= '0;
            stage2      <= '0;
            cap_pend    <= 1'b0;
            wr_ptr      <= '0;
        end else begin
            reg_rd_en <= 1'b0;
            reg_wr_en <= 1'b0;
            if (reg_rd_en) cap_pend <= 1'b1;
            if (sel_fall) begin
                stat_lo  <= stat_word[DATA_W-1:0];
                slot     <= SLOT_STAT_HI;
                stage1   <= '0;
                stage2   <= '0;
                cap_pend <= 1'b0;
            end else if (byte_done) begin
                slot   <= (slot == SLOT_STAT_HI) ? SLOT_STAT_LO : SLOT_DATA;
                stage2 <= stage1;
                stage1 <= '0;
                unique case (state)
                    ST_CMD, ST_RD: begin
                        if (cmd_rd && (cmd_addr != DUMMY_ADDR)) begin
                            reg_rd_en <= 1'b1;
                            reg_addr  <= cmd_addr;
                        end
                        if (state == ST_CMD && !cmd_rd) wr_ptr <= cmd_addr;
                    end
                    ST_WR: begin
                        reg_wr_en   <= 1'b1;
                        reg_addr    <= wr_ptr;
                        reg_wr_data <= rx_byte;
                        wr_ptr      <= wr_ptr + 1'b1;
                    end
                    default: ;
                endcase
            end else if (cap_pend) begin
                stage1   <= reg_rd_data;
                cap_pend <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/spi_regif_chk.sv
module spi_regif_chk #(
    parameter int                ADDR_W     = 7,
    parameter logic [ADDR_W-1:0] DUMMY_ADDR = 7'h3F
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_s,
    input logic              sdo,
    input logic              rd_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [ADDR_W-1:0] wr_ptr
);

    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));

    p_rd_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);

    p_wr_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    p_no_flush_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (addr != DUMMY_ADDR));

    p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_ptr == ADDR_W'(addr + 1'b1)));

    p_sdo_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sel_s |=> !sdo);

endmodule

bind spi_regif spi_regif_chk #(.ADDR_W(ADDR_W), .DUMMY_ADDR(DUMMY_ADDR)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_s  (sel_s),
    .sdo    (spi_sdo),
    .rd_en  (reg_rd_en),
    .wr_en  (reg_wr_en),
    .addr   (reg_addr),
    .wr_ptr (wr_ptr)
);

// File: tb/test_spi_regif.sv
module test_spi_regif;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        spi_sel_n, spi_sck, spi_sdi, spi_sdo;
    logic [15:0] stat_word;
    logic [6:0]  reg_addr;
    logic        reg_rd_en, reg_wr_en;
    logic [7:0]  reg_rd_data, reg_wr_data;

    int n_checks = 0;
    int n_fail   = 0;
    int rd_cnt   = 0;
    int wr_cnt   = 0;
    int strobe_err = 0;
    logic prev_rd = 1'b0, prev_wr = 1'b0;

    logic [7:0] mem     [128];
    logic [7:0] exp_mem [128];
    logic [7:0] tx_buf  [8];
    logic [7:0] rx_buf  [8];

    always #5 clk = ~clk;

    spi_regif i_spi_regif (
        .clk(clk), .rst_n(rst_n), .spi_sel_n(spi_sel_n), .spi_sck(spi_sck),
        .spi_sdi(spi_sdi), .spi_sdo(spi_sdo), .stat_word(stat_word),
        .reg_addr(reg_addr), .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data)
    );

    // register file model: read data valid the clock after the strobe
    always @(posedge clk) begin
        if (reg_wr_en) mem[reg_addr] <= reg_wr_data;
        if (reg_rd_en) reg_rd_data <= mem[reg_addr];
        if (rst_n) begin
            rd_cnt  <= rd_cnt + int'(reg_rd_en);
            wr_cnt  <= wr_cnt + int'(reg_wr_en);
            if ((reg_rd_en && reg_wr_en) || (reg_rd_en && prev_rd) || (reg_wr_en && prev_wr))
                strobe_err <= strobe_err + 1;
            prev_rd <= reg_rd_en;
            prev_wr <= reg_wr_en;
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic spi_run(input int nbits);
        spi_sel_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            spi_sdi = tx_buf[i/8][7-(i%8)];
            repeat (HALF) @(negedge clk);
            rx_buf[i/8][7-(i%8)] = spi_sdo;
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        spi_sel_n = 1'b1;
        repeat (4*HALF) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R11 sdo at reset", {15'd0, spi_sdo}, 16'd0);
        check("R10 strobes at reset", {14'd0, reg_rd_en, reg_wr_en}, 16'd0);
    endtask

    task automatic t_single_read;
        int r0;
        r0 = rd_cnt;
        stat_word = 16'hA55A;
        tx_buf[0] = 8'h90; tx_buf[1] = 8'h85;
        tx_buf[2] = 8'hBF; tx_buf[3] = 8'hBF; tx_buf[4] = 8'hBF;
        spi_run(40);
        check("R2 status high", {8'd0, rx_buf[0]}, 16'h00A5);
        check("R2 status low",  {8'd0, rx_buf[1]}, 16'h005A);
        check("R4 R1 read slot2", {8'd0, rx_buf[2]}, {8'd0, exp_mem[8'h10]});
        check("R4 read slot3",    {8'd0, rx_buf[3]}, {8'd0, exp_mem[8'h05]});
        check("R5 flush slot data", {8'd0, rx_buf[4]}, 16'd0);
        check("R5 read strobes", 16'(rd_cnt - r0), 16'd2);
    endtask

    task automatic t_any_order;
        stat_word = 16'h0F1E;
        tx_buf[0] = 8'hFF; tx_buf[1] = 8'h80; tx_buf[2] = 8'hC5;
        tx_buf[3] = 8'hBF; tx_buf[4] = 8'hBF;
        spi_run(40);
        check("R4 order 7F", {8'd0, rx_buf[2]}, {8'd0, exp_mem[8'h7F]});
        check("R4 order 00", {8'd0, rx_buf[3]}, {8'd0, exp_mem[8'h00]});
        check("R4 order 45", {8'd0, rx_buf[4]}, {8'd0, exp_mem[8'h45]});
    endtask

    task automatic t_status_hold;
        stat_word = 16'h1234;
        tx_buf[0] = 8'hBF; tx_buf[1] = 8'hBF;
        fork
            spi_run(16);
            begin
                repeat (40) @(negedge clk);
                stat_word = 16'hEDCB;
            end
        join
        check("R3 status sample", {rx_buf[0], rx_buf[1]}, 16'h1234);
    endtask

    task automatic t_single_write;
        int w0;
        w0 = wr_cnt;
        tx_buf[0] = 8'h22; tx_buf[1] = 8'hA5;
        spi_run(16);
        exp_mem[8'h22] = 8'hA5;
        check("R6 write strobes", 16'(wr_cnt - w0), 16'd1);
        tx_buf[0] = 8'hA2; tx_buf[1] = 8'hBF; tx_buf[2] = 8'hBF;
        spi_run(24);
        check("R6 readback", {8'd0, rx_buf[2]}, {8'd0, exp_mem[8'h22]});
    endtask

    task automatic t_wrap_write;
        int w0;
        w0 = wr_cnt;
        tx_buf[0] = 8'h7E; tx_buf[1] = 8'h11; tx_buf[2] = 8'h22; tx_buf[3] = 8'h33;
        spi_run(32);
        exp_mem[8'h7E] = 8'h11; exp_mem[8'h7F] = 8'h22; exp_mem[8'h00] = 8'h33;
        check("R7 write strobes", 16'(wr_cnt - w0), 16'd3);
        tx_buf[0] = 8'hFE; tx_buf[1] = 8'hFF; tx_buf[2] = 8'h80;
        tx_buf[3] = 8'hBF; tx_buf[4] = 8'hBF;
        spi_run(40);
        check("R7 at 7E", {8'd0, rx_buf[2]}, 16'h0011);
        check("R7 at 7F", {8'd0, rx_buf[3]}, 16'h0022);
        check("R7 wrap 00", {8'd0, rx_buf[4]}, 16'h0033);
    endtask

    task automatic t_ignored_byte;
        int r0, w0;
        r0 = rd_cnt; w0 = wr_cnt;
        tx_buf[0] = 8'h90; tx_buf[1] = 8'h05;
        tx_buf[2] = 8'hBF; tx_buf[3] = 8'hBF; tx_buf[4] = 8'hBF;
        spi_run(40);
        check("R8 first read", {8'd0, rx_buf[2]}, {8'd0, exp_mem[8'h10]});
        check("R8 ignored slot", {8'd0, rx_buf[3]}, 16'd0);
        check("R8 read strobes", 16'(rd_cnt - r0), 16'd1);
        check("R8 write strobes", 16'(wr_cnt - w0), 16'd0);
    endtask

    task automatic t_abort;
        int w0;
        w0 = wr_cnt;
        tx_buf[0] = 8'h05; tx_buf[1] = 8'hC3;
        spi_run(12);
        check("R9 no write", 16'(wr_cnt - w0), 16'd0);
        stat_word = 16'h6789;
        tx_buf[0] = 8'h85; tx_buf[1] = 8'hBF; tx_buf[2] = 8'hBF;
        spi_run(24);
        check("R9 restart status", {rx_buf[0], rx_buf[1]}, 16'h6789);
        check("R9 data kept", {8'd0, rx_buf[2]}, {8'd0, exp_mem[8'h05]});
    endtask

    task automatic run_all;
        t_reset();
        t_single_read();
        t_any_order();
        t_status_hold();
        t_single_write();
        t_wrap_write();
        t_ignored_byte();
        t_abort();
        check("R10 strobe shape", 16'(strobe_err), 16'd0);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) begin
            mem[i]     = 8'((i * 37 + 11) ^ (i >> 2));
            exp_mem[i] = 8'((i * 37 + 11) ^ (i >> 2));
        end
        reg_rd_data = 8'h00;
        rst_n = 1'b0; spi_sel_n = 1'b1; spi_sck = 1'b0; spi_sdi = 1'b0;
        stat_word = 16'h0000;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule